// File: doc/BRIEF.md
# Supply Undervoltage Lockout Qualifier

This block turns two sampled supply readings into the gate-enable masks of a half-bridge driver. One reading is the main supply, which feeds the logic and the low-side stage. The other is the floating bootstrap supply of the high-side stage. Each reading arrives every clock cycle as an unsigned millivolt code.

Each supply has its own pair of thresholds. The lockout engages when the reading falls under the lower threshold and releases when the reading climbs to the upper one, so the lockout has hysteresis. The lockout engages only after the reading has stayed under the lower threshold for a set number of consecutive cycles. A shorter dip is ignored, and the dip count starts again from zero. Release takes effect on the first cycle the reading is at or above the upper threshold.

A main-supply lockout removes both enables. A bootstrap lockout removes only the high-side enable. The lockout never feeds any fault-reporting path. After reset both supplies count as undervoltage, and each enable stays low until its supplies have been seen healthy.

Top module: `uvlo_qualifier`

## Requirements
- R1: During reset and on the first sample after it, lo_en_o and hi_en_o are both 0.
- R2: While the main supply is locked out, a main reading at or above MAIN_RISE_MV (default 12000) releases it at the next clock edge. lo_en_o then goes to 1, and hi_en_o also goes to 1 if the bootstrap supply is not locked out.
- R3: A healthy supply becomes locked out at the clock edge that takes its FILT_CYC-th consecutive sample below its falling threshold. FILT_CYC-1 consecutive samples below the threshold leave it healthy.
- R4: A single sample at or above the falling threshold while a supply is healthy restarts its count of consecutive low samples from zero.
- R5: A reading between the falling and rising thresholds leaves the supply's current state unchanged, whether that state is locked out or healthy.
- R6: A main-supply lockout drives both lo_en_o and hi_en_o to 0, and hi_en_o is never 1 while lo_en_o is 0.
- R7: A bootstrap lockout drives hi_en_o to 0 and leaves lo_en_o unchanged.
- R8: The bootstrap supply uses its own thresholds: it falls at BOOT_FALL_MV (default 11100) and rises at BOOT_RISE_MV (default 11700). Its filter works the same way as the main supply's.
- R9: A reading exactly equal to a falling threshold counts as healthy. A reading exactly equal to a rising threshold releases the lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| main_mv_i | input | MV_W | Main (logic and low-side) supply reading in mV |
| boot_mv_i | input | MV_W | Bootstrap (high-side) supply reading in mV |
| lo_en_o | output | 1 | Low-side gate enable |
| hi_en_o | output | 1 | High-side gate enable |

## Verification
Each output is one register stage after the reading that changes it. A release appears one edge after the qualifying sample. A lockout appears on the edge of the FILT_CYC-th consecutive low sample.

The bench drives readings on the falling clock edge and compares both enables one falling edge later. Between the drive and the compare there is exactly one rising edge, which the bench's own per-edge model also steps through. The filter is set to 8 cycles, so the sweeps can run dips of every length from 1 to 10 samples at values on, just inside and just outside each threshold.

// File: rtl/uvlo_pkg.sv
package uvlo_pkg;

  // Undervoltage test: strictly below the falling threshold.
  function automatic logic mv_under(input logic [31:0] mv, input logic [31:0] fall_mv);
    return mv < fall_mv;
  endfunction

  // Recovery test: at or above the rising threshold.
  function automatic logic mv_restored(input logic [31:0] mv, input logic [31:0] rise_mv);
    return mv >= rise_mv;
  endfunction

  // Width of a counter that holds 0..n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/supply_monitor.sv
module supply_monitor
  import uvlo_pkg::*;
#(
  parameter int unsigned MV_W     = 16,
  parameter int unsigned FALL_MV  = 11400,
  parameter int unsigned RISE_MV  = 12000,
  parameter int unsigned FILT_CYC = 1250
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [MV_W-1:0] mv_i,
  output logic            healthy_o
);
  localparam int unsigned CW = cnt_width(FILT_CYC);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic          healthy_q;
  logic [CW-1:0] dip_cnt_q;
  logic          low_sample;
  logic          back_up;
  logic          dip_expire;

  assign low_sample = mv_under(32'(mv_i), 32'(FALL_MV));
  assign back_up    = mv_restored(32'(mv_i), 32'(RISE_MV));
  assign dip_expire = healthy_q && low_sample && (dip_cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      healthy_q <= 1'b0;
      dip_cnt_q <= '0;
    end else if (healthy_q) begin
      if (dip_expire) begin
        healthy_q <= 1'b0;
        dip_cnt_q <= '0;
      end else if (low_sample) begin
        dip_cnt_q <= dip_cnt_q + 1'b1;
      end else begin
        dip_cnt_q <= '0;
      end
    end else begin
      dip_cnt_q <= '0;
      if (back_up) healthy_q <= 1'b1;
    end
  end

  assign healthy_o = healthy_q;

  // R3
  lockout_needs_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(healthy_q) |-> $past(dip_expire));
  // R2
  release_needs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(healthy_q) |-> $past(back_up));
  // R4
  dip_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dip_cnt_q <= LAST);
  // R4
  dip_cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (healthy_q && !low_sample) |=> (dip_cnt_q == '0));
  // R5
  idle_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !healthy_q |=> (!healthy_q || dip_cnt_q == '0));

endmodule

// File: rtl/enable_mask.sv
module enable_mask (
  input  logic main_ok_i,
  input  logic boot_ok_i,
  output logic lo_en_o,
  output logic hi_en_o
);
  // Main supply gates both sides; bootstrap gates the high side only.
  assign lo_en_o = main_ok_i;
  assign hi_en_o = main_ok_i & boot_ok_i;
endmodule

// File: rtl/uvlo_qualifier.sv
module uvlo_qualifier #(
  parameter int unsigned MV_W         = 16,
  parameter int unsigned MAIN_FALL_MV = 11400,
  parameter int unsigned MAIN_RISE_MV = 12000,
  parameter int unsigned BOOT_FALL_MV = 11100,
  parameter int unsigned BOOT_RISE_MV = 11700,
  parameter int unsigned FILT_CYC     = 1250
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [MV_W-1:0] main_mv_i,
  input  logic [MV_W-1:0] boot_mv_i,
  output logic            lo_en_o,
  output logic            hi_en_o
);
  logic main_ok;
  logic boot_ok;

  supply_monitor #(
    .MV_W(MV_W), .FALL_MV(MAIN_FALL_MV), .RISE_MV(MAIN_RISE_MV), .FILT_CYC(FILT_CYC)
  ) u_main_mon (
    .clk(clk), .rst_n(rst_n), .mv_i(main_mv_i), .healthy_o(main_ok)
  );

  supply_monitor #(
    .MV_W(MV_W), .FALL_MV(BOOT_FALL_MV), .RISE_MV(BOOT_RISE_MV), .FILT_CYC(FILT_CYC)
  ) u_boot_mon (
    .clk(clk), .rst_n(rst_n), .mv_i(boot_mv_i), .healthy_o(boot_ok)
  );

  enable_mask u_mask (
    .main_ok_i(main_ok), .boot_ok_i(boot_ok), .lo_en_o(lo_en_o), .hi_en_o(hi_en_o)
  );

  // R6
  hi_implies_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_en_o |-> lo_en_o);
  // R7
  boot_spares_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(boot_ok) && $stable(main_ok)) |-> $stable(lo_en_o));
  // R1
  reset_off_chk: assert property (@(posedge clk)
    !rst_n |-> (!lo_en_o && !hi_en_o));

endmodule

// File: tb/uvlo_qualifier_tb.sv
module uvlo_qualifier_tb;
  localparam int F  = 8;
  localparam int MF = 11400, MR = 12000, BF = 11100, BR = 11700;

  logic clk = 0;
  logic rst_n = 0;
  logic [15:0] main_mv = 0, boot_mv = 0;
  logic lo_en, hi_en;
  int n_chk = 0, n_fail = 0;

  // bench reference: run length of low samples per supply
  bit m_ok = 0, b_ok = 0;
  int m_run = 0, b_run = 0;

  always #4 clk = ~clk;

  uvlo_qualifier #(.MV_W(16), .MAIN_FALL_MV(MF), .MAIN_RISE_MV(MR),
    .BOOT_FALL_MV(BF), .BOOT_RISE_MV(BR), .FILT_CYC(F)) u_dut (
    .clk(clk), .rst_n(rst_n), .main_mv_i(main_mv), .boot_mv_i(boot_mv),
    .lo_en_o(lo_en), .hi_en_o(hi_en));

  task automatic check(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b (t=%0t)", what, act, exp, $time);
    end
  endtask

  task automatic ref_step(inout bit ok, inout int run, input int mv, input int fall, input int rise);
    if (!ok) begin
      run = 0;
      ok  = (mv >= rise);
    end else if (mv < fall) begin
      run = run + 1;
      if (run >= F) begin ok = 0; run = 0; end
    end else begin
      run = 0;
    end
  endtask

  task automatic apply(input int mm, input int bb, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      main_mv = 16'(mm); boot_mv = 16'(bb);
      @(negedge clk);
      ref_step(m_ok, m_run, mm, MF, MR);
      ref_step(b_ok, b_run, bb, BF, BR);
      check(lo_en, m_ok, {tag, " lo_en"});
      check(hi_en, m_ok & b_ok, {tag, " hi_en"});
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    main_mv = 16'(MR); boot_mv = 16'(BR);
    repeat (3) @(negedge clk);
    check(lo_en, 0, "R1 reset lo_en");
    check(hi_en, 0, "R1 reset hi_en");
    rst_n = 1;
    // R1 first edge after reset takes the first sample; R9 exact rise releases
    apply(MR, BR, 3, "R9/R2 release at exact rising threshold");
    // R5 healthy main between thresholds stays on
    apply(MR - 1, BR, 20, "R5 healthy hold");
    // R9 exactly at the falling threshold is healthy
    apply(MF, BF, 20, "R9 at falling threshold");
    // R3 F-1 low samples do not lock out
    apply(MF - 1, BR, F - 1, "R3 short dip");
    // R4 one good sample restarts the count
    apply(MF, BR, 1, "R4 restart");
    apply(MF - 1, BR, F - 1, "R4 after restart");
    // R3/R6 the F-th low sample locks out both sides
    apply(MF - 1, BR, 1, "R3/R6 lockout");
    check(lo_en, 0, "R6 lo_en off"); check(hi_en, 0, "R6 hi_en off");
    // R5 locked out main between thresholds stays off
    apply(MR - 1, BR, 15, "R5 locked hold");
    apply(MR, BR, 1, "R2 release");
    check(lo_en, 1, "R2 lo_en on"); check(hi_en, 1, "R2 hi_en on");
    // R7/R8 bootstrap lockout removes only high side
    apply(MR, BF - 1, F, "R7/R8 boot lockout");
    check(lo_en, 1, "R7 lo_en kept"); check(hi_en, 0, "R7 hi_en off");
    apply(MR, BR - 1, 10, "R8 boot hysteresis hold");
    apply(MR, BR, 1, "R8 boot release");
    check(hi_en, 1, "R8 hi_en back");
    // sweeps: dips of every length at values around each threshold
    for (int d = 1; d <= F + 2; d++) begin
      for (int k = 0; k < 4; k++) begin
        int vm, vb;
        vm = (k == 0) ? MF - 1 : (k == 1) ? MF : (k == 2) ? MR - 1 : 0;
        vb = (k == 0) ? BF : (k == 1) ? BF - 1 : (k == 2) ? 0 : BR - 1;
        apply(vm, vb, d, "R3/R5/R8 sweep dip");
        apply(MR - 1, BR - 1, 3, "R5 sweep mid");
        apply(MR, BR, 2, "R2/R9 sweep recover");
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule